// File: doc/BRIEF.md
# Decimating Gain-Tracking Front End

This block sits between a 6-bit tracking converter and the peak-search and offset logic of a differential magnetic sensor. Every system clock it takes one raw converter sample. It adds up eight consecutive samples and drops the lowest bit of the sum, so it emits one 8-bit sample per eight clocks, together with a one-clock valid strobe.

The block also owns the index of a gain stage whose steps are powers of two. The gain falls by one step at once when the converter reports an overrun. It also falls by one step when sixteen output-switching events pass without a peak being found. It rises by one step only on an offset-update strobe, and only when the minimum and maximum presented with that strobe both lie inside a central window. A separate input sends the index back to zero. Whenever the index actually changes, the block pulses a change flag so that downstream search logic can restart. At the same moment it discards its partial sum, so that no output mixes samples taken at two gain settings.

Top module: `gain_front_end`

## Requirements
- R1: Each delivered sample equals the sum of the eight converter samples taken at the eight rising edges that end with the one on which `dec_vld` rises, shifted right by one bit (sum[8:1]). It appears on `dec_out` in the same cycle as `dec_vld`.
- R2: Counted from reset release or from the last gain change, `dec_vld` is high for exactly one cycle after every eighth sample and low in every other cycle.
- R3: A high `smp_ovr` at a rising edge lowers `gain_idx` by one from the next cycle on.
- R4: At an edge where `upd_stb` is high, `gain_idx` rises by one only if `upd_min` >= 0x50 and `upd_max` < 0xB0 (unsigned). With `upd_min` = 0x4F, with `upd_max` = 0xB0, or with `upd_stb` low, the index is unchanged.
- R5: `gain_idx` stays within 0 to 6 and never wraps. A lower request at 0, or a raise request at 6, leaves it unchanged and produces no `gain_chg`.
- R6: When a lower request and a raise request arrive at the same edge, the index is lowered.
- R7: A high `gain_clear` sets `gain_idx` to 0 at the next edge. It has priority over all other requests.
- R8: The sixteenth `sw_evt` pulse since the last `peak_found`, reset or previous watchdog step lowers `gain_idx` by one, and the count then restarts. A `peak_found` pulse restarts the count.
- R9: `gain_chg` is high for exactly the one cycle in which `gain_idx` first shows a new value. It stays low when a request leaves the index unchanged.
- R10: At the edge where the gain index changes, the partial sum and the sample of that cycle are discarded. The next `dec_vld` comes after eight further samples and covers only those samples.
- R11: During and right after reset, `gain_idx` is 0 and `dec_out`, `dec_vld` and `gain_chg` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_in | input | 6 | Raw converter sample |
| smp_ovr | input | 1 | Converter overrun flag |
| upd_stb | input | 1 | Offset-update strobe |
| upd_min | input | 8 | Recent minimum on the 8-bit scale |
| upd_max | input | 8 | Recent maximum on the 8-bit scale |
| sw_evt | input | 1 | Output-switching event pulse |
| peak_found | input | 1 | A minimum or maximum was identified |
| gain_clear | input | 1 | Force gain index to 0 |
| dec_out | output | 8 | Decimated sample |
| dec_vld | output | 1 | One-cycle valid strobe for `dec_out` |
| gain_idx | output | 3 | Current gain index, 0 to 6 |
| gain_chg | output | 1 | One-cycle pulse on a gain index change |

## Verification
Every gain request (overrun, window raise, clear, or the sixteenth switching event) shows on `gain_idx` and `gain_chg` one cycle after the edge that samples it. The bench therefore checks both 1 ns after that edge and checks again one edge later to confirm that the pulse has ended. A decimated value appears in the cycle after its eighth sample is taken. The bench counts samples from reset release or from the known edge of a gain change, checks `dec_vld` is low on each of the first seven and checks value and strobe on the eighth. All inputs change 1 ns after a rising edge, and all outputs are read there as well.

// File: rtl/gfe_pkg.sv
package gfe_pkg;

   typedef enum logic [1:0] {
      GA_HOLD  = 2'd0,
      GA_DOWN  = 2'd1,
      GA_UP    = 2'd2,
      GA_CLEAR = 2'd3
   } gain_act_e;

endpackage

// File: rtl/gfe_decim.sv
module gfe_decim #(
   parameter int SMP_W    = 6,
   parameter int DEC_LOG2 = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr_i,
   input  logic [SMP_W-1:0]            smp_i,
   output logic [SMP_W+DEC_LOG2-2:0]   dout_o,
   output logic                        vld_o
);
   localparam int DEC_N = 1 << DEC_LOG2;
   localparam int ACC_W = SMP_W + DEC_LOG2;
   localparam int CNT_W = DEC_LOG2;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEC_N - 1);

   generate
      if (DEC_LOG2 < 1) begin : g_bad_ratio
         $error("gfe_decim: DEC_LOG2 must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] sum;

   // full-width sum: DEC_N samples of SMP_W bits cannot exceed ACC_W bits
   assign sum = acc_q + ACC_W'(smp_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         acc_q  <= '0;
         dout_o <= '0;
         vld_o  <= 1'b0;
      end else if (clr_i) begin
         cnt_q <= '0;
         acc_q <= '0;
         vld_o <= 1'b0;
      end else begin
         vld_o <= 1'b0;
         if (cnt_q == CNT_LAST) begin
            dout_o <= sum[ACC_W-1:1];
            vld_o  <= 1'b1;
            acc_q  <= '0;
            cnt_q  <= '0;
         end else begin
            acc_q <= sum;
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R2
   vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |=> !vld_o);

   // R10
   clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (!vld_o && cnt_q == '0));

endmodule

// File: rtl/gfe_gain_ctrl.sv
module gfe_gain_ctrl
   import gfe_pkg::*;
#(
   parameter int              GAIN_STEPS = 7,
   parameter int              PK_W       = 8,
   parameter logic [PK_W-1:0] WIN_LO     = 8'h50,
   parameter logic [PK_W-1:0] WIN_HI     = 8'hB0,
   parameter int              STALL_EVTS = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clear_i,
   input  logic                          ovr_i,
   input  logic                          upd_i,
   input  logic [PK_W-1:0]               min_i,
   input  logic [PK_W-1:0]               max_i,
   input  logic                          sw_i,
   input  logic                          peak_i,
   output logic [$clog2(GAIN_STEPS)-1:0] idx_o,
   output logic                          chg_o,
   output logic                          chg_now_o
);
   localparam int IDX_W = $clog2(GAIN_STEPS);
   localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(GAIN_STEPS - 1);

   generate
      if (GAIN_STEPS < 2) begin : g_bad_steps
         $error("gfe_gain_ctrl: GAIN_STEPS must be at least 2");
      end
      if (STALL_EVTS == 1) begin : g_bad_stall
         $error("gfe_gain_ctrl: STALL_EVTS must be 0 or at least 2");
      end
   endgenerate

   logic            stall_dn;
   logic            up_ok;
   gain_act_e       act;
   logic [IDX_W-1:0] idx_nxt;

   generate
      if (STALL_EVTS > 0) begin : g_stall
         localparam int SC_W = $clog2(STALL_EVTS);
         localparam logic [SC_W-1:0] SC_LAST = SC_W'(STALL_EVTS - 1);
         logic [SC_W-1:0] sc_q;
         assign stall_dn = sw_i && !peak_i && (sc_q == SC_LAST);
         always_ff @(posedge clk) begin
            if (!rst_n || clear_i || peak_i) begin
               sc_q <= '0;
            end else if (sw_i) begin
               sc_q <= (sc_q == SC_LAST) ? '0 : sc_q + 1'b1;
            end
         end
      end else begin : g_no_stall
         assign stall_dn = 1'b0;
      end
   endgenerate

   assign up_ok = upd_i && (min_i >= WIN_LO) && (max_i < WIN_HI);

   always_comb begin
      if (clear_i)                act = GA_CLEAR;
      else if (ovr_i || stall_dn) act = GA_DOWN;
      else if (up_ok)             act = GA_UP;
      else                        act = GA_HOLD;
   end

   always_comb begin
      idx_nxt = idx_o;
      case (act)
         GA_CLEAR: idx_nxt = '0;
         GA_DOWN:  if (idx_o != '0) idx_nxt = idx_o - 1'b1;
         GA_UP:    if (idx_o != IDX_MAX) idx_nxt = idx_o + 1'b1;
         default:  idx_nxt = idx_o;
      endcase
   end

   assign chg_now_o = (idx_nxt != idx_o);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_o <= '0;
         chg_o <= 1'b0;
      end else begin
         idx_o <= idx_nxt;
         chg_o <= chg_now_o;
      end
   end

   // R5
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_o <= IDX_MAX);

   // R3
   ovr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_i && !clear_i && idx_o != '0) |=> (idx_o == $past(idx_o) - IDX_W'(1)));

   // R7
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (idx_o == '0));

   // R9
   chg_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_o != $past(idx_o)) |-> chg_o);

endmodule

// File: rtl/gain_front_end.sv
module gain_front_end #(
   parameter int       SMP_W      = 6,
   parameter int       DEC_LOG2   = 3,
   parameter int       GAIN_STEPS = 7,
   parameter int       PK_W       = 8,
   parameter logic [7:0] WIN_LO   = 8'h50,
   parameter logic [7:0] WIN_HI   = 8'hB0,
   parameter int       STALL_EVTS = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [SMP_W-1:0]              smp_in,
   input  logic                          smp_ovr,
   input  logic                          upd_stb,
   input  logic [PK_W-1:0]               upd_min,
   input  logic [PK_W-1:0]               upd_max,
   input  logic                          sw_evt,
   input  logic                          peak_found,
   input  logic                          gain_clear,
   output logic [SMP_W+DEC_LOG2-2:0]     dec_out,
   output logic                          dec_vld,
   output logic [$clog2(GAIN_STEPS)-1:0] gain_idx,
   output logic                          gain_chg
);
   generate
      if (SMP_W < 2) begin : g_bad_width
         $error("gain_front_end: SMP_W must be at least 2");
      end
      if (PK_W != 8) begin : g_bad_pk
         $error("gain_front_end: window limits assume an 8-bit peak scale");
      end
   endgenerate

   logic chg_now;

   gfe_gain_ctrl #(
      .GAIN_STEPS (GAIN_STEPS),
      .PK_W       (PK_W),
      .WIN_LO     (WIN_LO),
      .WIN_HI     (WIN_HI),
      .STALL_EVTS (STALL_EVTS)
   ) u_gain (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (gain_clear),
      .ovr_i     (smp_ovr),
      .upd_i     (upd_stb),
      .min_i     (upd_min),
      .max_i     (upd_max),
      .sw_i      (sw_evt),
      .peak_i    (peak_found),
      .idx_o     (gain_idx),
      .chg_o     (gain_chg),
      .chg_now_o (chg_now)
   );

   gfe_decim #(
      .SMP_W    (SMP_W),
      .DEC_LOG2 (DEC_LOG2)
   ) u_decim (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (chg_now),
      .smp_i  (smp_in),
      .dout_o (dec_out),
      .vld_o  (dec_vld)
   );

   // R9
   chg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gain_chg |=> !gain_chg || (gain_idx != $past(gain_idx)));

   // R10
   chg_no_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gain_chg |-> !dec_vld);

endmodule

// File: tb/sim_gain_front_end.sv
module sim_gain_front_end;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] smp_in = '0;
   logic       smp_ovr = 1'b0;
   logic       upd_stb = 1'b0;
   logic [7:0] upd_min = '0;
   logic [7:0] upd_max = '0;
   logic       sw_evt = 1'b0;
   logic       peak_found = 1'b0;
   logic       gain_clear = 1'b0;
   logic [7:0] dec_out;
   logic       dec_vld;
   logic [2:0] gain_idx;
   logic       gain_chg;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   gain_front_end u0 (
      .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .smp_ovr(smp_ovr),
      .upd_stb(upd_stb), .upd_min(upd_min), .upd_max(upd_max),
      .sw_evt(sw_evt), .peak_found(peak_found), .gain_clear(gain_clear),
      .dec_out(dec_out), .dec_vld(dec_vld), .gain_idx(gain_idx),
      .gain_chg(gain_chg)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one rising edge, then settle 1 ns before inputs change or outputs are read
   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic idle_strobes();
      smp_ovr = 0; upd_stb = 0; sw_evt = 0; peak_found = 0; gain_clear = 0;
   endtask

   task automatic t_reset();
      rst_n = 0;
      repeat (3) tick();
      check("R11 idx", gain_idx, 0);
      check("R11 vld", dec_vld, 0);
      check("R11 out", dec_out, 0);
      check("R11 chg", gain_chg, 0);
      rst_n = 1;
   endtask

   // eight samples from a known phase; value on the eighth
   task automatic t_window(input int base, input int stepv, input string req);
      int sum = 0;
      for (int i = 0; i < 8; i++) begin
         smp_in = 6'((base + i * stepv) % 64);
         sum += (base + i * stepv) % 64;
         tick();
         if (i < 7) check({req, " R2 vld low"}, dec_vld, 0);
      end
      check({req, " R2 vld high"}, dec_vld, 1);
      check({req, " R1 value"}, dec_out, sum >> 1);
   endtask

   task automatic t_decim();
      t_window(0, 9, "ramp");
      t_window(63, 0, "full");
      t_window(5, 13, "wrap");
      smp_in = 0;
      tick();
      check("R2 vld drops", dec_vld, 0);
   endtask

   task automatic up_req(input int mn, input int mx);
      upd_stb = 1; upd_min = 8'(mn); upd_max = 8'(mx);
      tick();
      idle_strobes();
   endtask

   task automatic t_raise();
      up_req(8'h50, 8'hAF);
      check("R4 raise idx", gain_idx, 1);
      check("R9 raise chg", gain_chg, 1);
      tick();
      check("R9 chg one cycle", gain_chg, 0);
      up_req(8'h4F, 8'h80);
      check("R4 min below window", gain_idx, 1);
      check("R9 no chg", gain_chg, 0);
      up_req(8'h80, 8'hB0);
      check("R4 max at limit", gain_idx, 1);
      upd_min = 8'h80; upd_max = 8'h90;
      tick();
      check("R4 no strobe", gain_idx, 1);
   endtask

   task automatic t_top_sat();
      for (int i = 0; i < 5; i++) up_req(8'h60, 8'hA0);
      check("R4 reach top", gain_idx, 6);
      up_req(8'h60, 8'hA0);
      check("R5 top hold", gain_idx, 6);
      check("R5 top no chg", gain_chg, 0);
   endtask

   task automatic t_down();
      smp_ovr = 1;
      tick();
      idle_strobes();
      check("R3 overrun", gain_idx, 5);
      check("R9 overrun chg", gain_chg, 1);
      smp_ovr = 1; upd_stb = 1; upd_min = 8'h60; upd_max = 8'hA0;
      tick();
      idle_strobes();
      check("R6 down wins", gain_idx, 4);
   endtask

   task automatic sw_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         sw_evt = 1;
         tick();
      end
      sw_evt = 0;
   endtask

   task automatic t_stall();
      sw_pulses(15);
      check("R8 fifteen events", gain_idx, 4);
      sw_pulses(1);
      check("R8 sixteenth event", gain_idx, 3);
      check("R8 chg", gain_chg, 1);
      sw_pulses(10);
      peak_found = 1;
      tick();
      peak_found = 0;
      sw_pulses(15);
      check("R8 peak restarts", gain_idx, 3);
      sw_pulses(1);
      check("R8 after restart", gain_idx, 2);
   endtask

   task automatic t_clear();
      gain_clear = 1; smp_ovr = 1; upd_stb = 1;
      tick();
      idle_strobes();
      check("R7 clear", gain_idx, 0);
      check("R7 clear chg", gain_chg, 1);
      gain_clear = 1;
      tick();
      idle_strobes();
      check("R9 clear at zero no chg", gain_chg, 0);
      smp_ovr = 1;
      tick();
      idle_strobes();
      check("R5 bottom hold", gain_idx, 0);
      check("R5 bottom no chg", gain_chg, 0);
      sw_pulses(16);
      check("R5 stall at bottom", gain_idx, 0);
      check("R5 stall no chg", gain_chg, 0);
   endtask

   task automatic t_realign();
      up_req(8'h60, 8'hA0);
      check("R10 setup idx", gain_idx, 1);
      smp_in = 63;
      for (int i = 0; i < 3; i++) begin
         tick();
         check("R10 partial vld", dec_vld, 0);
      end
      smp_ovr = 1;
      tick();
      idle_strobes();
      check("R10 change idx", gain_idx, 0);
      check("R10 no vld at change", dec_vld, 0);
      t_window(10, 0, "R10 realigned");
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_decim();
            t_raise();
            t_top_sat();
            t_down();
            t_stall();
            t_clear();
            t_realign();
         end
         begin
            repeat (20000) @(posedge clk);
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule